// File: doc/BRIEF.md
# CCD Horizontal Line Timing Generator

This block produces every per-line timing signal for an interline colour CCD clocked by an 18 MHz pixel clock. A free-running position counter wraps after a fixed number of clocks. That position is decoded into registered outputs:

- a line sync;
- a window for vertical charge transfer inside the blanking interval, with a strobe and an index for each vertical step;
- an overflow-drain shutter window;
- two complementary horizontal shift phases and a reset-gate enable;
- three one-hot flags that tell downstream capture logic whether the current sample is pre-scan, leading black or an output pixel.

A single mode input selects the vertical step spacing. It is 28 clocks in field accumulation mode (`mode_frame` = 0) and 56 clocks in frame accumulation mode (`mode_frame` = 1). The block samples the mode only on the transition into line position 0, so a mode change always applies from the next line. Every output is one register stage away from the counter decode. All outputs therefore share one alignment: in each cycle they describe the same line position.

Top module: `ccd_line_timer`

## Requirements
- R1: One line lasts 2640 clocks. `hsync` is high for line positions 0 to 15 and low for the remaining positions of every line.
- R2: `v_win` is high exactly for line positions 54 to 259.
- R3: With field mode in force for the line, `v_step` pulses for one clock at positions 54 + 28k, for k = 0 to 7. `v_idx` equals (position − 54) / 28 inside `v_win` and is 0 outside it.
- R4: With frame mode in force for the line, `v_step` pulses at positions 54 + 56k, for k = 0 to 3. `v_idx` equals (position − 54) / 56 inside `v_win` and is 0 outside it.
- R5: `mode_frame` is sampled only when the counter enters position 0. A change made in the middle of a line leaves the rest of that line unchanged.
- R6: The readout order is fixed. `pc_pre` is high for positions 278 to 301 (24 clocks). `pc_ob` is high for positions 302 to 303 (2 clocks). `pc_act` is high for positions 304 to 2399 (2096 clocks). At most one of the three flags is high at any time.
- R7: `h1` and `h2` are always complementary. During readout (positions 278 to 2399), `h1` is high on even positions and low on odd positions. Outside readout, `h1` is held at 1 and `h2` at 0, which includes the whole of `v_win`.
- R8: `rg_en` is high on every readout position (278 to 2399) and low at all other positions.
- R9: `ofd_win` is high for positions 152 to 207 in field-mode lines. It never rises in frame-mode lines.
- R10: While `rst_n` is low, the outputs hold the idle state of the last line position: every output is 0 except `h1`, which is 1. The first clock edge after release presents position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_frame | input | 1 | 0 selects field spacing, 1 selects frame spacing; sampled at line start |
| hsync | output | 1 | Line sync at the start of each line |
| v_win | output | 1 | Vertical transfer window within blanking |
| v_step | output | 1 | One-clock strobe at each vertical phase step |
| v_idx | output | 3 | Index of the current vertical step inside the window |
| ofd_win | output | 1 | Overflow-drain shutter window, field mode only |
| h1 | output | 1 | Horizontal shift phase 1 |
| h2 | output | 1 | Horizontal shift phase 2 |
| rg_en | output | 1 | Reset-gate enable, once per read clock |
| pc_pre | output | 1 | Sample is pre-scan |
| pc_ob | output | 1 | Sample is leading optical black |
| pc_act | output | 1 | Sample is an output pixel |

## Verification
A corrupted position counter shifts every window at once. The shift appears at the very next `hsync` or readout boundary, at most one line (2640 clocks) later. A step gap counter that is out of phase moves `v_step` and `v_idx` within the same blanking interval, 28 or 56 clocks after the fault. A mode latch that updates mid-line shows as a changed step spacing or a missing `ofd_win` on the line where the change was made, before the next line begins. The bench compares every output against its arithmetic model on every clock of five lines, so each of these faults is reported at the first cycle where it shows at the ports.

// File: rtl/ccd_line_timer.sv
module ccd_line_timer #(
  parameter int LINE_LEN  = 2640,
  parameter int HSYNC_W   = 16,
  parameter int VSTART    = 54,
  parameter int VEND      = 260,
  parameter int VSP_FIELD = 28,
  parameter int VSP_FRAME = 56,
  parameter int OFD_START = 152,
  parameter int OFD_END   = 208,
  parameter int RD_START  = 278,
  parameter int PRESCAN   = 24,
  parameter int OB_PIX    = 2,
  parameter int OUT_PIX   = 2096,
  parameter int IDXW      = $clog2((VEND - VSTART + VSP_FIELD - 1) / VSP_FIELD)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_frame,
  output logic            hsync,
  output logic            v_win,
  output logic            v_step,
  output logic [IDXW-1:0] v_idx,
  output logic            ofd_win,
  output logic            h1,
  output logic            h2,
  output logic            rg_en,
  output logic            pc_pre,
  output logic            pc_ob,
  output logic            pc_act
);
  localparam int CW = $clog2(LINE_LEN);
  localparam int GW = $clog2(VSP_FRAME > VSP_FIELD ? VSP_FRAME : VSP_FIELD);

  localparam logic [CW-1:0] C_LAST = CW'(LINE_LEN - 1);
  localparam logic [CW-1:0] C_HS   = CW'(HSYNC_W);
  localparam logic [CW-1:0] C_VS   = CW'(VSTART);
  localparam logic [CW-1:0] C_VE   = CW'(VEND);
  localparam logic [CW-1:0] C_OS   = CW'(OFD_START);
  localparam logic [CW-1:0] C_OE   = CW'(OFD_END);
  localparam logic [CW-1:0] C_RS   = CW'(RD_START);
  localparam logic [CW-1:0] C_PE   = CW'(RD_START + PRESCAN);
  localparam logic [CW-1:0] C_BE   = CW'(RD_START + PRESCAN + OB_PIX);
  localparam logic [CW-1:0] C_RE   = CW'(RD_START + PRESCAN + OB_PIX + OUT_PIX);
  localparam logic [GW-1:0] G_FI   = GW'(VSP_FIELD - 1);
  localparam logic [GW-1:0] G_FR   = GW'(VSP_FRAME - 1);

  logic [CW-1:0]   cnt, nxt;
  logic            mode_q, m_n;
  logic [GW-1:0]   gap, gap_n, gap_top;
  logic [IDXW-1:0] idx_n;
  logic            win_n, edge_n, rd_n;

  assign nxt     = (cnt == C_LAST) ? '0 : cnt + 1'b1;
  assign m_n     = (nxt == '0) ? mode_frame : mode_q;
  assign gap_top = m_n ? G_FR : G_FI;
  assign win_n   = (nxt >= C_VS) && (nxt < C_VE);
  assign gap_n   = (nxt == C_VS || gap == gap_top) ? '0 : gap + 1'b1;
  assign edge_n  = win_n && (gap_n == '0);
  assign idx_n   = (!win_n || nxt == C_VS) ? '0 : (edge_n ? v_idx + 1'b1 : v_idx);
  assign rd_n    = (nxt >= C_RS) && (nxt < C_RE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= C_LAST;
      mode_q  <= 1'b0;
      gap     <= '0;
      hsync   <= 1'b0;
      v_win   <= 1'b0;
      v_step  <= 1'b0;
      v_idx   <= '0;
      ofd_win <= 1'b0;
      h1      <= 1'b1;
      h2      <= 1'b0;
      rg_en   <= 1'b0;
      pc_pre  <= 1'b0;
      pc_ob   <= 1'b0;
      pc_act  <= 1'b0;
    end else begin
      cnt     <= nxt;
      mode_q  <= m_n;
      gap     <= gap_n;
      hsync   <= nxt < C_HS;
      v_win   <= win_n;
      v_step  <= edge_n;
      v_idx   <= idx_n;
      ofd_win <= !m_n && (nxt >= C_OS) && (nxt < C_OE);
      h1      <= rd_n ? ~nxt[0] : 1'b1;
      h2      <= rd_n ? nxt[0] : 1'b0;
      rg_en   <= rd_n;
      pc_pre  <= (nxt >= C_RS) && (nxt < C_PE);
      pc_ob   <= (nxt >= C_PE) && (nxt < C_BE);
      pc_act  <= (nxt >= C_BE) && (nxt < C_RE);
    end
  end
endmodule

// File: rtl/ccd_line_timer_chk.sv
module ccd_line_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_l,
  input logic hsync,
  input logic v_win,
  input logic v_step,
  input logic ofd_win,
  input logic h1,
  input logic h2,
  input logic rg_en,
  input logic pc_pre,
  input logic pc_ob,
  input logic pc_act
);
  p_hsync_blank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |-> (!rg_en && !v_win));
  p_step_in_win_r3: assert property (@(posedge clk) disable iff (!rst_n)
    v_step |-> v_win);
  p_flags_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_pre, pc_ob, pc_act}));
  p_pre_then_ob_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pc_pre) |-> pc_ob);
  p_h_comp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    h1 != h2);
  p_h_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    v_win |-> (h1 && !h2));
  p_rg_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    v_win |-> !rg_en);
  p_ofd_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ofd_win |-> !mode_l);
endmodule

bind ccd_line_timer ccd_line_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_l(mode_q), .hsync(hsync), .v_win(v_win),
  .v_step(v_step), .ofd_win(ofd_win), .h1(h1), .h2(h2), .rg_en(rg_en),
  .pc_pre(pc_pre), .pc_ob(pc_ob), .pc_act(pc_act)
);

// File: tb/ccd_line_timer_tb_top.sv
module ccd_line_timer_tb_top;
  localparam int LINE = 2640;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_frame = 1'b0;
  logic hsync, v_win, v_step, ofd_win, h1, h2, rg_en, pc_pre, pc_ob, pc_act;
  logic [2:0] v_idx;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ccd_line_timer dut_i (
    .clk(clk), .rst_n(rst_n), .mode_frame(mode_frame), .hsync(hsync),
    .v_win(v_win), .v_step(v_step), .v_idx(v_idx), .ofd_win(ofd_win),
    .h1(h1), .h2(h2), .rg_en(rg_en), .pc_pre(pc_pre), .pc_ob(pc_ob),
    .pc_act(pc_act)
  );

  task automatic chk(input string req, input int p, input int got, input int exp);
    vecs++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s pos=%0d got=%0d exp=%0d", req, p, got, exp);
    end
  endtask

  task automatic check_pos(input int p, input bit lm, input string tag);
    int sp;
    bit vw, rd;
    sp = lm ? 56 : 28;
    vw = (p >= 54) && (p < 260);
    rd = (p >= 278) && (p < 2400);
    chk({"R1 hsync ", tag}, p, int'(hsync), int'(p < 16));
    chk({"R2 v_win ", tag}, p, int'(v_win), int'(vw));
    chk({lm ? "R4" : "R3", " v_step ", tag}, p, int'(v_step), int'(vw && ((p - 54) % sp == 0)));
    chk({lm ? "R4" : "R3", " v_idx ", tag}, p, int'(v_idx), vw ? (p - 54) / sp : 0);
    chk({"R9 ofd_win ", tag}, p, int'(ofd_win), int'(!lm && p >= 152 && p < 208));
    chk({"R7 h1 ", tag}, p, int'(h1), rd ? int'(p % 2 == 0) : 1);
    chk({"R7 h2 ", tag}, p, int'(h2), rd ? int'(p % 2 == 1) : 0);
    chk({"R8 rg_en ", tag}, p, int'(rg_en), int'(rd));
    chk({"R6 pc_pre ", tag}, p, int'(pc_pre), int'(p >= 278 && p < 302));
    chk({"R6 pc_ob ", tag}, p, int'(pc_ob), int'(p >= 302 && p < 304));
    chk({"R6 pc_act ", tag}, p, int'(pc_act), int'(p >= 304 && p < 2400));
  endtask

  initial begin
    bit lm;
    int p;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_pos(LINE - 1, 1'b0, "R10 reset");
    rst_n = 1'b1;
    lm = 1'b0;
    for (int k = 0; k < 5 * LINE; k++) begin
      @(posedge clk);
      p = k % LINE;
      if (p == 0) lm = mode_frame;
      @(negedge clk);
      check_pos(p, lm, (k / LINE == 1 || k / LINE == 3) ? "R5 line" : "sweep");
      if (k == LINE + 1000) mode_frame = 1'b1;
      if (k == 3 * LINE + 100) mode_frame = 1'b0;
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule